// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block folds two sources of interrupt requests into one priority level. The first source is a software request vector and the second is an external status vector. Software requests sit in a configurable bit window. Each software request is re-based so that the lowest bit of its window counts as level 1. External requests sit in a second window and use their raw bit index as their level. Any external request outranks every software request. Each request bit that falls inside a window is also collected into a summary mask at its own bit position.

An evaluation runs only when the check-enable flag is armed and the core is in neither speculative nor privileged operation. An evaluation disarms the flag. If the resulting level is nonzero and strictly above the current priority level, the block does four things on the clock edge: it emits a one-cycle trap pulse, loads the summary register with the mask, loads the ID register with the level, and sets an entering-interrupt flag. The flag stays set until the consumer acknowledges it. If an asynchronous-trap request is pending during an evaluation, the block raises an error pulse, because that request is unsupported.

Top module: `intr_level_arbiter`

## Requirements
- R1: A software request bit i in the window [SW_MIN, SW_MAX) gives level i - SW_MIN + 1, and the highest set bit wins (defaults 1 and 16, so bit 15 gives level 15). Bits outside the window are ignored.
- R2: An external status bit i in the window [EXT_MIN, EXT_MAX) gives level i, and the highest set bit wins (defaults 16 and 32). Bits outside the window are ignored.
- R3: If any in-window external bit is set, the external level replaces the software level.
- R4: The summary mask has bit i set exactly when i is an in-window software or external request bit that is set. Every other bit is zero.
- R5: A trap is taken only when the level is nonzero and strictly greater than `curIpl`.
- R6: On the edge that takes a trap, `summaryReg` loads the mask, `intIdReg` loads the level, and `enteringIrq` is set. Without a trap, both registers hold their values.
- R7: No evaluation runs while `specMode` or `privMode` is high. The check-enable flag then stays armed.
- R8: `chkEnSet` arms `chkEn` on the next edge. An evaluation clears it. When `chkEn` is clear, no trap is taken.
- R9: An evaluation with `asyncTrapReq` high drives `asyncErr` high for the next cycle.
- R10: `enteringIrq` stays high until an `irqAck` edge clears it. A new trap on the same edge wins over the acknowledge.
- R11: `trapPulse` is high for exactly the one cycle after the evaluation edge that takes the trap.
- R12: Reset clears `trapPulse`, `enteringIrq`, `chkEn`, `asyncErr`, `summaryReg` and `intIdReg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swReq | input | VW | Software interrupt request vector |
| extStatus | input | VW | External interrupt status vector |
| curIpl | input | LW | Current interrupt priority level |
| chkEnSet | input | 1 | Arms the check-enable flag |
| specMode | input | 1 | Speculative operation, blocks evaluation |
| privMode | input | 1 | Privileged mode, blocks evaluation |
| asyncTrapReq | input | 1 | Pending asynchronous-trap request (unsupported) |
| irqAck | input | 1 | Clears the entering-interrupt flag |
| chkEn | output | 1 | Check-enable flag |
| trapPulse | output | 1 | One-cycle trap strobe |
| enteringIrq | output | 1 | Entering-interrupt flag |
| asyncErr | output | 1 | Unsupported asynchronous-trap error pulse |
| summaryReg | output | VW | Interrupt summary register |
| intIdReg | output | LW | Interrupt ID register |

## Verification
The hardest situation to reach is an evaluation that is held off by mode and then released. The armed flag must survive a stretch of speculative operation, then a stretch of privileged operation, and still fire once both clear. The bench arms the flag while the request is visible and keeps it blocked for several cycles in each mode, checking `chkEn` and the ID register at each step. It then drops both modes and expects the trap on the following edge. The boundary where the level equals `curIpl` is hit directly, with a level one above it as the contrast case.

// File: rtl/intr_level_pkg.sv
package intr_level_pkg;
  typedef struct packed {
    logic loadSummary;
    logic loadId;
  } dpStrobe_t;
endpackage

// File: rtl/intr_level_dp.sv
module intr_level_dp
  import intr_level_pkg::*;
#(
  parameter int VW      = 64,
  parameter int LW      = 5,
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [VW-1:0] swReq,
  input  logic [VW-1:0] extStatus,
  input  logic [LW-1:0] curIpl,
  input  dpStrobe_t     strobe,
  output logic          aboveIpl,
  output logic [VW-1:0] summaryReg,
  output logic [LW-1:0] intIdReg
);
  logic [LW-1:0] swLvl, extLvl, level;
  logic [VW-1:0] mask;
  logic          extHit;

  // Priority scan: later (higher) indices overwrite earlier ones.
  always_comb begin
    swLvl  = '0;
    extLvl = '0;
    extHit = 1'b0;
    mask   = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (swReq[i]) begin
        swLvl   = LW'(i - SW_MIN + 1);
        mask[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (extStatus[i]) begin
        extLvl  = LW'(i);
        extHit  = 1'b1;
        mask[i] = 1'b1;
      end
    end
    level    = extHit ? extLvl : swLvl;
    aboveIpl = (level != '0) && (level > curIpl);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      summaryReg <= '0;
      intIdReg   <= '0;
    end else begin
      if (strobe.loadSummary) summaryReg <= mask;
      if (strobe.loadId)      intIdReg   <= level;
    end
  end
endmodule

// File: rtl/intr_level_ctrl.sv
module intr_level_ctrl
  import intr_level_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chkEnSet,
  input  logic      specMode,
  input  logic      privMode,
  input  logic      asyncTrapReq,
  input  logic      irqAck,
  input  logic      aboveIpl,
  output dpStrobe_t strobe,
  output logic      chkEn,
  output logic      trapPulse,
  output logic      enteringIrq,
  output logic      asyncErr
);
  logic checkRun, takeTrap;

  assign checkRun = chkEn & ~specMode & ~privMode;
  assign takeTrap = checkRun & aboveIpl;

  always_comb begin
    strobe.loadSummary = takeTrap;
    strobe.loadId      = takeTrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkEn       <= 1'b0;
      trapPulse   <= 1'b0;
      enteringIrq <= 1'b0;
      asyncErr    <= 1'b0;
    end else begin
      chkEn       <= chkEnSet | (chkEn & ~checkRun);
      trapPulse   <= takeTrap;
      enteringIrq <= takeTrap | (enteringIrq & ~irqAck);
      asyncErr    <= checkRun & asyncTrapReq;
    end
  end
endmodule

// File: rtl/intr_level_arbiter.sv
module intr_level_arbiter
  import intr_level_pkg::*;
#(
  parameter int VW      = 64,
  parameter int LW      = 5,
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [VW-1:0] swReq,
  input  logic [VW-1:0] extStatus,
  input  logic [LW-1:0] curIpl,
  input  logic          chkEnSet,
  input  logic          specMode,
  input  logic          privMode,
  input  logic          asyncTrapReq,
  input  logic          irqAck,
  output logic          chkEn,
  output logic          trapPulse,
  output logic          enteringIrq,
  output logic          asyncErr,
  output logic [VW-1:0] summaryReg,
  output logic [LW-1:0] intIdReg
);
  dpStrobe_t strobe;
  logic      aboveIpl;

  intr_level_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .chkEnSet(chkEnSet), .specMode(specMode),
    .privMode(privMode), .asyncTrapReq(asyncTrapReq), .irqAck(irqAck),
    .aboveIpl(aboveIpl), .strobe(strobe), .chkEn(chkEn),
    .trapPulse(trapPulse), .enteringIrq(enteringIrq), .asyncErr(asyncErr)
  );

  intr_level_dp #(
    .VW(VW), .LW(LW), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
  ) i_dp (
    .clk(clk), .rstN(rstN), .swReq(swReq), .extStatus(extStatus),
    .curIpl(curIpl), .strobe(strobe), .aboveIpl(aboveIpl),
    .summaryReg(summaryReg), .intIdReg(intIdReg)
  );
endmodule

// File: rtl/intr_level_arbiter_chk.sv
module intr_level_arbiter_chk #(
  parameter int VW      = 64,
  parameter int LW      = 5,
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic [LW-1:0] curIpl,
  input logic          chkEnSet,
  input logic          specMode,
  input logic          privMode,
  input logic          asyncTrapReq,
  input logic          chkEn,
  input logic          trapPulse,
  input logic          enteringIrq,
  input logic          asyncErr,
  input logic [VW-1:0] summaryReg,
  input logic [LW-1:0] intIdReg
);
  function automatic logic [VW-1:0] windowMask();
    logic [VW-1:0] m = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) m[i] = 1'b1;
    for (int i = EXT_MIN; i < EXT_MAX; i++) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [VW-1:0] WIN = windowMask();

  assert_mask_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (summaryReg & ~WIN) == '0);
  assert_trap_above_ipl_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> (intIdReg != '0) && (intIdReg > $past(curIpl)));
  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !trapPulse |-> $stable(summaryReg) && $stable(intIdReg));
  assert_entering_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> enteringIrq);
  assert_mode_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(chkEn && !specMode && !privMode));
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(chkEn && !specMode && !privMode && !chkEnSet) |-> !chkEn);
  assert_async_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    asyncErr |-> $past(asyncTrapReq && chkEn));
endmodule

bind intr_level_arbiter intr_level_arbiter_chk #(
  .VW(VW), .LW(LW), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
  .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
) i_chk (
  .clk(clk), .rstN(rstN), .curIpl(curIpl), .chkEnSet(chkEnSet),
  .specMode(specMode), .privMode(privMode), .asyncTrapReq(asyncTrapReq),
  .chkEn(chkEn), .trapPulse(trapPulse), .enteringIrq(enteringIrq),
  .asyncErr(asyncErr), .summaryReg(summaryReg), .intIdReg(intIdReg)
);

// File: tb/test_intr_level_arbiter.sv
module test_intr_level_arbiter;
  localparam int VW = 64;
  localparam int LW = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic [VW-1:0] swReq = '0, extStatus = '0;
  logic [LW-1:0] curIpl = '0;
  logic chkEnSet = 0, specMode = 0, privMode = 0, asyncTrapReq = 0, irqAck = 0;
  logic chkEn, trapPulse, enteringIrq, asyncErr;
  logic [VW-1:0] summaryReg;
  logic [LW-1:0] intIdReg;
  int checks = 0, errors = 0;
  logic [VW-1:0] heldMask = '0;
  logic [LW-1:0] heldId = '0;

  always #4 clk = ~clk;

  intr_level_arbiter i_intr_level_arbiter (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Arm the flag with inputs set; evaluation happens on the following edge.
  task automatic arm(input logic [VW-1:0] sw, input logic [VW-1:0] ex, input logic [LW-1:0] ipl);
    @(negedge clk);
    swReq = sw; extStatus = ex; curIpl = ipl; chkEnSet = 1;
    @(negedge clk);
    chkEnSet = 0;
  endtask

  task automatic expectTrap(input string req, input logic [VW-1:0] m, input logic [LW-1:0] id);
    @(negedge clk);
    chk(req, trapPulse, 1);
    chk(req, summaryReg, m);
    chk(req, intIdReg, id);
    chk(req, enteringIrq, 1);
    chk("R8", chkEn, 0);
    heldMask = m; heldId = id;
    @(negedge clk);
    chk("R11", trapPulse, 0);
  endtask

  task automatic expectNoTrap(input string req);
    @(negedge clk);
    chk(req, trapPulse, 0);
    chk(req, summaryReg, heldMask);
    chk(req, intIdReg, heldId);
  endtask

  task automatic t_reset;
    chk("R12", trapPulse, 0); chk("R12", enteringIrq, 0); chk("R12", chkEn, 0);
    chk("R12", asyncErr, 0); chk("R12", summaryReg, 0); chk("R12", intIdReg, 0);
  endtask

  task automatic t_softLevel;  // R1: bits 3 and 15 in window, 0 and 16 outside
    arm(64'h0001_8009, '0, 5'd0);
    expectTrap("R1", 64'h0000_8008, 5'd15);
  endtask

  task automatic t_softRebase;  // R1: bit 4 -> level 4
    arm(64'h10, '0, 5'd0);
    expectTrap("R1", 64'h10, 5'd4);
  endtask

  task automatic t_extLevel;  // R2: bits 18, 25 in window; bits 40, 2 outside
    arm('0, 64'h0000_0100_0204_0004, 5'd0);
    expectTrap("R2", 64'h0204_0000, 5'd25);
  endtask

  task automatic t_extOverride;  // R3 and R4: software 15 loses to external 16
    arm(64'h8000, 64'h1_0000, 5'd0);
    expectTrap("R3", 64'h1_8000, 5'd16);
  endtask

  task automatic t_equalIpl;  // R5: level equal to curIpl, no trap
    arm(64'h80, '0, 5'd7);
    expectNoTrap("R5");
    chk("R8", chkEn, 0);
  endtask

  task automatic t_oneAbove;  // R5: level 20 over ipl 19 traps
    arm('0, 64'h10_0000, 5'd19);
    expectTrap("R5", 64'h10_0000, 5'd20);
  endtask

  task automatic t_zeroLevel;  // R5: nothing set
    arm('0, '0, 5'd0);
    expectNoTrap("R5");
  endtask

  task automatic t_noFlag;  // R8: no arming, no trap
    @(negedge clk);
    extStatus = 64'h4000_0000; curIpl = 0;
    repeat (3) expectNoTrap("R8");
    chk("R8", chkEn, 0);
  endtask

  task automatic t_suppress;  // R7
    @(negedge clk);
    specMode = 1; extStatus = 64'h4000_0000; curIpl = 0; chkEnSet = 1;
    @(negedge clk);
    chkEnSet = 0;
    repeat (3) expectNoTrap("R7");
    chk("R7", chkEn, 1);
    specMode = 0; privMode = 1;
    repeat (3) expectNoTrap("R7");
    chk("R7", chkEn, 1);
    privMode = 0;
    expectTrap("R7", 64'h4000_0000, 5'd30);
  endtask

  task automatic t_entering;  // R10
    repeat (2) @(negedge clk);
    chk("R10", enteringIrq, 1);
    irqAck = 1;
    @(negedge clk);
    irqAck = 0;
    chk("R10", enteringIrq, 0);
  endtask

  task automatic t_async;  // R9
    @(negedge clk);
    asyncTrapReq = 1;
    arm('0, '0, 5'd0);
    @(negedge clk);
    chk("R9", asyncErr, 1);
    asyncTrapReq = 0;
    @(negedge clk);
    chk("R9", asyncErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    t_softLevel();
    t_softRebase();
    t_extLevel();
    t_extOverride();
    t_equalIpl();
    t_oneAbove();
    t_zeroLevel();
    t_noFlag();
    t_suppress();
    t_entering();
    t_async();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule